// File: doc/BRIEF.md
# Receive Byte Clock Generator

This block turns a recovered bit-rate clock into the byte clocks that a receive data path uses to register parallel characters. A bit counter marks a character boundary every `BITS` bit times. A static mode input picks one of two output styles. Full-speed mode gives a single clock at one `BITS`-th of the bit rate. Half-speed mode gives a complementary pair at half that rate, so the rising edges on the two outputs fall on alternate character boundaries.

When the comma aligner decides that the character boundary has to move, it raises a one-cycle realign request that carries a bit offset. The block then holds its bit counter for that many bit times. The clock phase in progress (high or low) therefore grows longer and is never cut short, and the outputs never show a narrow pulse. A one-cycle boundary strobe marks the first bit time of every character.

Top module: `rxbyteclk_gen`

## Requirements
- R1: In reset the bit counter is at zero and the boundary strobe is low. In full-speed mode (`full_mode`=1) `rbc1_o` is high and `rbc0_o` is low. In half-speed mode (`full_mode`=0) `rbc1_o` is low and `rbc0_o` is high.
- R2: Full-speed mode with no realignment: `rbc1_o` repeats every `BITS` bit cycles. It is high for the first `HI_BITS` cycles of each character and low for the rest. `rbc0_o` stays low.
- R3: Half-speed mode: `rbc1_o` toggles at every character boundary, and `rbc0_o` is always its inverse. With no realignment each level therefore lasts `BITS` cycles.
- R4: `char_start_o` is high for exactly one cycle: the first bit cycle of each character. In full-speed mode it coincides with each rise of `rbc1_o`.
- R5: A realign request with an offset n from 1 to `BITS`-1 is accepted when no stretch is running. It freezes the bit counter for n cycles, starting with the edge that samples the request, so the gap between two boundary strobes becomes `BITS`+n.
- R6: A realign request that arrives while a stretch is still running is ignored.
- R7: A realign request whose offset is 0 or at least `BITS` is ignored. The gap between strobes stays `BITS`.
- R8: Half-speed mode: the first character boundary after an accepted realign leaves `rbc1_o` high. If `rbc1_o` was low, it rises there. If it was already high, it stays high for one more character.
- R9: No output phase is ever shorter than nominal. In full-speed mode `rbc1_o` high runs last at least `HI_BITS` cycles and low runs at least `BITS`-`HI_BITS` cycles. In half-speed mode every run lasts at least `BITS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_mode | input | 1 | 1 = single full-speed clock, 0 = complementary half-speed pair |
| realign_req | input | 1 | One-cycle request to move the character boundary |
| realign_ofs | input | $clog2(BITS) | Bit offset of the request |
| rbc1_o | output | 1 | Byte clock 1 (the only clock in full-speed mode) |
| rbc0_o | output | 1 | Byte clock 0 (inverse of clock 1 in half-speed mode, low in full-speed mode) |
| char_start_o | output | 1 | Strobe for the first bit cycle of each character |

## Verification
The assertions assume that `full_mode` is held constant from reset onward, because a mode switch in mid-run could legitimately chop a phase. They also assume that requests are sampled on the bit clock. The bench changes `full_mode` only while reset is asserted. It drives requests and offsets one half-period away from the sampling edge, with the full 0–15 offset range, so that out-of-range and overlapping requests occur alongside legal ones.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;
   typedef enum logic {
      MODE_HALF = 1'b0,
      MODE_FULL = 1'b1
   } rbc_mode_e;
endpackage

// File: rtl/rxbc_bitcnt.sv
module rxbc_bitcnt #(
   parameter int BITS = 10,
   parameter int CW   = $clog2(BITS)
) (
   input  logic          clk_bit,
   input  logic          rst_n,
   input  logic          req,
   input  logic [CW-1:0] ofs,
   output logic [CW-1:0] cnt_q,
   output logic          wrap,
   output logic          accept,
   output logic          holding
);
   logic [CW-1:0] stall_q;
   logic [CW-1:0] eff;

   assign holding = (stall_q != '0);
   assign accept  = req && !holding && (ofs != '0) && (32'(ofs) < BITS);
   assign eff     = accept ? ofs : stall_q;
   assign wrap    = (eff == '0) && (cnt_q == CW'(BITS-1));

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stall_q <= '0;
      end else if (eff != '0) begin
         stall_q <= eff - CW'(1);
      end else begin
         cnt_q   <= wrap ? '0 : cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/rxbc_phase.sv
module rxbc_phase (
   input  logic clk_bit,
   input  logic rst_n,
   input  logic wrap,
   input  logic accept,
   output logic ph_q,
   output logic force_q,
   output logic bnd_q
);
   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= 1'b0;
         force_q <= 1'b0;
         bnd_q   <= 1'b0;
      end else begin
         bnd_q <= wrap;
         if (wrap) begin
            ph_q    <= force_q ? 1'b1 : ~ph_q;
            force_q <= 1'b0;
         end else if (accept) begin
            force_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxbyteclk_gen.sv
module rxbyteclk_gen
   import rxbc_pkg::*;
#(
   parameter int BITS    = 10,
   parameter int HI_BITS = BITS / 2,
   parameter int CW      = $clog2(BITS)
) (
   input  logic          clk_bit,
   input  logic          rst_n,
   input  logic          full_mode,
   input  logic          realign_req,
   input  logic [CW-1:0] realign_ofs,
   output logic          rbc1_o,
   output logic          rbc0_o,
   output logic          char_start_o
);
   localparam int LO_BITS = BITS - HI_BITS;

   if (BITS < 4) begin : g_bad_bits
      $error("rxbyteclk_gen: BITS must be at least 4");
   end
   if (HI_BITS < 1 || LO_BITS < 1) begin : g_bad_hi
      $error("rxbyteclk_gen: HI_BITS must lie in 1..BITS-1");
   end

   rbc_mode_e     mode;
   logic [CW-1:0] cnt;
   logic          wrap;
   logic          accept;
   logic          holding;
   logic          ph;
   logic          force_q;
   logic          full_hi;

   assign mode = rbc_mode_e'(full_mode);

   rxbc_bitcnt #(.BITS(BITS), .CW(CW)) u_cnt (
      .clk_bit (clk_bit),
      .rst_n   (rst_n),
      .req     (realign_req),
      .ofs     (realign_ofs),
      .cnt_q   (cnt),
      .wrap    (wrap),
      .accept  (accept),
      .holding (holding)
   );

   rxbc_phase u_ph (
      .clk_bit (clk_bit),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .accept  (accept),
      .ph_q    (ph),
      .force_q (force_q),
      .bnd_q   (char_start_o)
   );

   if (HI_BITS == LO_BITS) begin : g_sym
      assign full_hi = (cnt < CW'(HI_BITS));
   end else begin : g_asym
      assign full_hi = (32'(cnt) < HI_BITS);
   end

   always_comb begin
      if (mode == MODE_FULL) begin
         rbc1_o = full_hi;
         rbc0_o = 1'b0;
      end else begin
         rbc1_o = ph;
         rbc0_o = ~ph;
      end
   end
endmodule

// File: rtl/rxbc_chk.sv
module rxbc_chk #(
   parameter int BITS    = 10,
   parameter int HI_BITS = BITS / 2,
   parameter int CW      = $clog2(BITS)
) (
   input logic          clk_bit,
   input logic          rst_n,
   input logic          full_mode,
   input logic          rbc1_o,
   input logic          char_start_o,
   input logic [CW-1:0] cnt,
   input logic          accept,
   input logic          wrap,
   input logic          force_q
);
   localparam int RW = $clog2(4 * BITS) + 1;
   localparam int MIN_HI = HI_BITS;
   localparam int MIN_LO = BITS - HI_BITS;

   logic [RW-1:0] hi_run, lo_run;
   logic          prev1, valid_q;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= '0;
         lo_run  <= '0;
         prev1   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         prev1   <= rbc1_o;
         valid_q <= 1'b1;
         if (rbc1_o) begin
            lo_run <= '0;
            if (hi_run != '1) hi_run <= hi_run + RW'(1);
         end else begin
            hi_run <= '0;
            if (lo_run != '1) lo_run <= lo_run + RW'(1);
         end
      end
   end

   a_r4_strobe_on_rise: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (valid_q && full_mode && rbc1_o && !prev1) |-> char_start_o);

   a_r4_strobe_single: assert property (@(posedge clk_bit) disable iff (!rst_n)
      char_start_o |=> !char_start_o);

   a_r5_freeze: assert property (@(posedge clk_bit) disable iff (!rst_n)
      accept |=> $stable(cnt));

   a_r8_force_high: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (!full_mode && force_q && wrap) |=> rbc1_o);

   a_r9_min_high: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (valid_q && prev1 && !rbc1_o) |-> (32'(hi_run) >= (full_mode ? MIN_HI : BITS)));

   a_r9_min_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (valid_q && !prev1 && rbc1_o) |-> (32'(lo_run) >= (full_mode ? MIN_LO : BITS)));
endmodule

bind rxbyteclk_gen rxbc_chk #(.BITS(BITS), .HI_BITS(HI_BITS), .CW(CW)) u_chk (
   .clk_bit      (clk_bit),
   .rst_n        (rst_n),
   .full_mode    (full_mode),
   .rbc1_o       (rbc1_o),
   .char_start_o (char_start_o),
   .cnt          (cnt),
   .accept       (accept),
   .wrap         (wrap),
   .force_q      (force_q)
);

// File: tb/rxbyteclk_gen_tb.sv
module rxbyteclk_gen_tb;
   localparam int BITS = 10;
   localparam int HI   = BITS / 2;
   localparam int CW   = $clog2(BITS);

   logic          clk_bit = 1'b0;
   logic          rst_n = 1'b0;
   logic          full_mode = 1'b1;
   logic          realign_req = 1'b0;
   logic [CW-1:0] realign_ofs = '0;
   logic          rbc1_o, rbc0_o, char_start_o;

   int checks = 0;
   int failures = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #10 clk_bit = ~clk_bit;

   rxbyteclk_gen #(.BITS(BITS)) u_dut (
      .clk_bit      (clk_bit),
      .rst_n        (rst_n),
      .full_mode    (full_mode),
      .realign_req  (realign_req),
      .realign_ofs  (realign_ofs),
      .rbc1_o       (rbc1_o),
      .rbc0_o       (rbc0_o),
      .char_start_o (char_start_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model of the requirements
   int m_cnt, m_stall;
   bit m_ph, m_force, m_bnd;

   function automatic bit exp_clk1();
      return full_mode ? (m_cnt < HI) : m_ph;
   endfunction

   function automatic bit exp_clk0();
      return full_mode ? 1'b0 : ~m_ph;
   endfunction

   always @(posedge clk_bit) begin
      if (!rst_n) begin
         m_cnt = 0; m_stall = 0; m_ph = 0; m_force = 0; m_bnd = 0;
      end else begin
         bit acc, wr;
         int eff;
         acc = realign_req && (m_stall == 0) && (realign_ofs != 0) && (int'(realign_ofs) < BITS);
         eff = acc ? int'(realign_ofs) : m_stall;
         wr = 0;
         if (eff != 0) m_stall = eff - 1;
         else if (m_cnt == BITS - 1) begin m_cnt = 0; wr = 1; end
         else m_cnt = m_cnt + 1;
         if (wr) begin m_ph = m_force ? 1'b1 : ~m_ph; m_force = 0; end
         else if (acc) m_force = 1;
         m_bnd = wr;
      end
   end

   // Continuous comparison plus run-length tracking
   int run = 0;
   bit prev1 = 1'b0;
   always @(negedge clk_bit) begin
      if (cmp_en && rst_n) begin
         chk(full_mode ? "R2 clk1" : "R3 clk1", int'(rbc1_o), int'(exp_clk1()));
         chk(full_mode ? "R2 clk0" : "R3 clk0", int'(rbc0_o), int'(exp_clk0()));
         chk("R4 strobe", int'(char_start_o), int'(m_bnd));
         if (rbc1_o == prev1) run++;
         else begin
            if (run > 0) begin
               if (full_mode) chk("R9 run", int'(run >= (prev1 ? HI : BITS - HI)), 1);
               else           chk("R9 run", int'(run >= BITS), 1);
            end
            run = 1;
         end
         prev1 = rbc1_o;
      end else begin
         run = 0;
         prev1 = rbc1_o;
      end
   end

   task automatic wait_strobe();
      do @(negedge clk_bit); while (!char_start_o);
   endtask

   // Request at a strobe, optional second request one cycle later; return strobe gap
   task automatic gap(input int o1, input bit second, input int o2, output int n);
      wait_strobe();
      realign_req = 1'b1; realign_ofs = CW'(o1);
      @(negedge clk_bit);
      n = 1;
      realign_req = second; realign_ofs = CW'(o2);
      while (!char_start_o) begin
         @(negedge clk_bit);
         realign_req = 1'b0;
         n++;
      end
      realign_req = 1'b0;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk_bit);
      rst_n = 1'b0; full_mode = mode; realign_req = 1'b0; realign_ofs = '0;
      repeat (3) @(negedge clk_bit);
      chk("R1 clk1", int'(rbc1_o), int'(mode));
      chk("R1 clk0", int'(rbc0_o), int'(!mode));
      chk("R1 strobe", int'(char_start_o), 0);
      rst_n = 1'b1;
   endtask

   task automatic random_run(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk_bit);
         realign_req = ($urandom % 6) == 0;
         realign_ofs = CW'($urandom % 16);
      end
      @(negedge clk_bit);
      realign_req = 1'b0;
   endtask

   initial begin
      int n;
      void'($urandom(32'd4242));
      do_reset(1'b1);
      cmp_en = 1'b1;
      // R2/R4: plain full-speed period
      wait_strobe();
      n = 0;
      do begin @(negedge clk_bit); n++; end while (!char_start_o);
      chk("R2 period", n, BITS);
      gap(3, 1'b0, 0, n);  chk("R5 gap ofs3", n, BITS + 3);
      gap(9, 1'b0, 0, n);  chk("R5 gap ofs9", n, BITS + 9);
      gap(4, 1'b1, 2, n);  chk("R6 ignored during stretch", n, BITS + 4);
      gap(0, 1'b0, 0, n);  chk("R7 ofs0", n, BITS);
      gap(12, 1'b0, 0, n); chk("R7 ofs12", n, BITS);
      random_run(600);

      do_reset(1'b0);
      wait_strobe();
      n = 0;
      do begin @(negedge clk_bit); n++; end while (!char_start_o);
      chk("R3 boundary gap", n, BITS);
      // R8: realign from low and from high phase
      do wait_strobe(); while (rbc1_o);
      gap(2, 1'b0, 0, n);
      chk("R8 from low", int'(rbc1_o), 1);
      do wait_strobe(); while (!rbc1_o);
      gap(5, 1'b0, 0, n);
      chk("R8 from high", int'(rbc1_o), 1);
      chk("R5 half gap", n, BITS + 5);
      random_run(600);

      cmp_en = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_bit);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule